// File: doc/BRIEF.md
# Return Address Stack with Speculative Repair

This block predicts the targets of subroutine returns. It keeps a bounded stack of return addresses. A call prediction pushes the return address, which is the call address plus 4. A return prediction reads the top entry as its target and pops it. While the stack holds entries, the predicted target is always visible on `predTarget`. When the stack is empty, `predTarget` shows zero.

Predictions are speculative. Each stack change made by a prediction is recorded in a small associative history table, keyed by the branch address. A record of zero marks a call. A nonzero record holds the target that a return removed.

When the pipeline squashes branches, it sends flushes in reverse program order. Each flush looks up its address, undoes the recorded change and frees the record. A flush that undoes a call pops the stack. A flush that undoes a return pushes the saved target back. When a branch retires, the update port frees its record without touching the stack.

Top module: `retStackRepair`

## Requirements
- R1: After reset, `stackDepth` is 0, `predTarget` is 0 and `histOverflow` is 0.
- R2: A call prediction (`predType` = 2'b01) pushes `predAddr`+4. On the next cycle `predTarget` shows that value and `stackDepth` has grown by one, unless the stack was already full.
- R3: A return prediction (`predType` = 2'b10) on a non-empty stack shows the top entry on `predTarget` in the same cycle. It then pops that entry, so `stackDepth` drops by one and the next-older entry becomes the target.
- R4: With the stack holding `DEPTH` entries, a call discards the oldest entry and `stackDepth` stays at `DEPTH`. Later returns give the newest `DEPTH` addresses in last-in, first-out order, and after that the target is 0.
- R5: A return on an empty stack predicts target 0, leaves the stack empty and records nothing. A later flush of its address therefore changes nothing.
- R6: A flush whose address matches a call record pops the stack, which undoes the call.
- R7: A flush whose address matches a return record pushes the recorded target back onto the stack.
- R8: A flush whose address matches no record leaves the stack unchanged.
- R9: An update whose address matches a record removes that record and leaves the stack unchanged. A later flush of that address therefore has no effect.
- R10: A new prediction that needs a record when all `HIST` records are in use sets `histOverflow`. The prediction still acts on the stack but is not recorded. `histOverflow` stays set until reset.
- R11: In a cycle with `flushValid` high, any predict or update request is ignored.
- R12: A prediction at an address that already has a record replaces that record.
- R13: A prediction of any other type (2'b00 or 2'b11) leaves the stack unchanged and records nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| predValid | input | 1 | A prediction request is present this cycle |
| predAddr | input | ADDR_W | Address of the predicted branch |
| predType | input | 2 | 01 call, 10 return, 00/11 other |
| predTarget | output | ADDR_W | Top of stack, or 0 when the stack is empty |
| flushValid | input | 1 | A flush request is present this cycle |
| flushAddr | input | ADDR_W | Address of the branch being squashed |
| updValid | input | 1 | A branch retires this cycle |
| updAddr | input | ADDR_W | Address of the retiring branch |
| stackDepth | output | $clog2(DEPTH+1) | Number of valid stack entries |
| histOverflow | output | 1 | Sticky flag: a prediction could not be recorded |

## Verification
The bench checks whether an empty-stack return leaves a record behind. If it did, a later flush at that address would pop an unrelated call and lower the depth. A return at an address that already holds a call record is also checked. A design that kept the old record would pop on the flush instead of restoring the saved target. Stack overflow is driven to check that the oldest entry is dropped, not the newest, and that the return order stays last-in, first-out. The bench also checks that a full history table raises the sticky flag without blocking the stack action, and that a request arriving alongside a flush is ignored.

// File: rtl/rasPkg.sv
package rasPkg;
  localparam logic [1:0] BR_CALL = 2'b01;
  localparam logic [1:0] BR_RET  = 2'b10;

  typedef struct packed {
    logic push;
    logic pop;
  } stackCmd_t;
endpackage

// File: rtl/rasStack.sv
module rasStack
  import rasPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 4,
  parameter int DW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  stackCmd_t         cmd,
  input  logic [ADDR_W-1:0] pushData,
  output logic [DW-1:0]     depth,
  output logic [ADDR_W-1:0] topVal,
  output logic              empty
);
  localparam int TW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [TW-1:0] LAST = TW'(DEPTH - 1);

  logic [ADDR_W-1:0] entries [DEPTH];
  logic [TW-1:0]     topIdx;
  logic [TW-1:0]     nxtIdx;
  logic [TW-1:0]     prvIdx;

  assign nxtIdx = (topIdx == LAST) ? '0 : topIdx + 1'b1;
  assign prvIdx = (topIdx == '0) ? LAST : topIdx - 1'b1;
  assign topVal = entries[topIdx];
  assign empty  = (depth == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      topIdx <= '0;
      depth  <= '0;
      for (int i = 0; i < DEPTH; i++) entries[i] <= '0;
    end else if (cmd.push) begin
      topIdx          <= nxtIdx;
      entries[nxtIdx] <= pushData;
      if (depth != DW'(DEPTH)) depth <= depth + 1'b1;
    end else if (cmd.pop && !empty) begin
      topIdx <= prvIdx;
      depth  <= depth - 1'b1;
    end
  end
endmodule

// File: rtl/rasCtrl.sv
module rasCtrl
  import rasPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int HIST   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              predValid,
  input  logic [ADDR_W-1:0] predAddr,
  input  logic [1:0]        predType,
  input  logic              flushValid,
  input  logic [ADDR_W-1:0] flushAddr,
  input  logic              updValid,
  input  logic [ADDR_W-1:0] updAddr,
  input  logic              stackEmpty,
  input  logic [ADDR_W-1:0] stackTop,
  output stackCmd_t         cmd,
  output logic [ADDR_W-1:0] pushData,
  output logic              histOverflow
);
  localparam int HW = (HIST > 1) ? $clog2(HIST) : 1;

  logic [HIST-1:0]   histValid;
  logic [ADDR_W-1:0] histAddr [HIST];
  logic [ADDR_W-1:0] histTgt  [HIST];

  logic [ADDR_W-1:0] lookAddr;
  logic              hit;
  logic [HW-1:0]     hitIdx;
  logic              freeFound;
  logic [HW-1:0]     freeIdx;
  logic              doRec;
  logic              doClear;
  logic [ADDR_W-1:0] recTgt;

  always_comb begin
    if (flushValid)     lookAddr = flushAddr;
    else if (predValid) lookAddr = predAddr;
    else                lookAddr = updAddr;
    hit = 1'b0;
    hitIdx = '0;
    freeFound = 1'b0;
    freeIdx = '0;
    for (int i = 0; i < HIST; i++) begin
      if (!hit && histValid[i] && histAddr[i] == lookAddr) begin
        hit = 1'b1;
        hitIdx = HW'(i);
      end
      if (!freeFound && !histValid[i]) begin
        freeFound = 1'b1;
        freeIdx = HW'(i);
      end
    end
  end

  always_comb begin
    cmd = '0;
    pushData = '0;
    doRec = 1'b0;
    doClear = 1'b0;
    recTgt = '0;
    if (flushValid) begin
      if (hit) begin
        doClear = 1'b1;
        if (histTgt[hitIdx] == '0) begin
          cmd.pop = !stackEmpty;
        end else begin
          cmd.push = 1'b1;
          pushData = histTgt[hitIdx];
        end
      end
    end else if (predValid) begin
      if (predType == BR_CALL) begin
        cmd.push = 1'b1;
        pushData = predAddr + ADDR_W'(4);
        doRec = 1'b1;
      end else if (predType == BR_RET && !stackEmpty) begin
        cmd.pop = 1'b1;
        doRec = 1'b1;
        recTgt = stackTop;
      end
    end else if (updValid && hit) begin
      doClear = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      histValid <= '0;
      histOverflow <= 1'b0;
      for (int i = 0; i < HIST; i++) begin
        histAddr[i] <= '0;
        histTgt[i] <= '0;
      end
    end else begin
      if (doClear) histValid[hitIdx] <= 1'b0;
      if (doRec) begin
        if (hit) begin
          histTgt[hitIdx] <= recTgt;
        end else if (freeFound) begin
          histValid[freeIdx] <= 1'b1;
          histAddr[freeIdx] <= predAddr;
          histTgt[freeIdx] <= recTgt;
        end else begin
          histOverflow <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/retStackRepair.sv
module retStackRepair
  import rasPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 4,
  parameter int HIST   = 4,
  parameter int DW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              predValid,
  input  logic [ADDR_W-1:0] predAddr,
  input  logic [1:0]        predType,
  output logic [ADDR_W-1:0] predTarget,
  input  logic              flushValid,
  input  logic [ADDR_W-1:0] flushAddr,
  input  logic              updValid,
  input  logic [ADDR_W-1:0] updAddr,
  output logic [DW-1:0]     stackDepth,
  output logic              histOverflow
);
  stackCmd_t         cmd;
  logic [ADDR_W-1:0] pushData;
  logic [ADDR_W-1:0] topVal;
  logic              empty;

  rasCtrl #(.ADDR_W(ADDR_W), .HIST(HIST)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .predValid(predValid), .predAddr(predAddr), .predType(predType),
    .flushValid(flushValid), .flushAddr(flushAddr),
    .updValid(updValid), .updAddr(updAddr),
    .stackEmpty(empty), .stackTop(topVal),
    .cmd(cmd), .pushData(pushData), .histOverflow(histOverflow)
  );

  rasStack #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .DW(DW)) u_stack (
    .clk(clk), .rstN(rstN), .cmd(cmd), .pushData(pushData),
    .depth(stackDepth), .topVal(topVal), .empty(empty)
  );

  assign predTarget = empty ? '0 : topVal;
endmodule

// File: rtl/retStackRepairChk.sv
module retStackRepairChk #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 4,
  parameter int DW     = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              predValid,
  input logic [1:0]        predType,
  input logic              flushValid,
  input logic [ADDR_W-1:0] predTarget,
  input logic [DW-1:0]     stackDepth,
  input logic              histOverflow
);
  p_depth_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    stackDepth <= DW'(DEPTH));

  p_call_grow_r2: assert property (@(posedge clk) disable iff (!rstN)
    predValid && !flushValid && predType == 2'b01 && stackDepth < DW'(DEPTH)
    |=> stackDepth == $past(stackDepth) + 1'b1);

  p_ret_shrink_r3: assert property (@(posedge clk) disable iff (!rstN)
    predValid && !flushValid && predType == 2'b10 && stackDepth != '0
    |=> stackDepth == $past(stackDepth) - 1'b1);

  p_empty_ret_r5: assert property (@(posedge clk) disable iff (!rstN)
    predValid && !flushValid && predType == 2'b10 && stackDepth == '0
    |-> predTarget == '0 ##1 stackDepth == '0);

  p_sticky_ovf_r10: assert property (@(posedge clk) disable iff (!rstN)
    histOverflow |=> histOverflow);

  p_plain_stable_r13: assert property (@(posedge clk) disable iff (!rstN)
    predValid && !flushValid && (predType == 2'b00 || predType == 2'b11)
    |=> $stable(stackDepth));
endmodule

bind retStackRepair retStackRepairChk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .DW(DW)) u_chk (
  .clk(clk), .rstN(rstN), .predValid(predValid), .predType(predType),
  .flushValid(flushValid), .predTarget(predTarget),
  .stackDepth(stackDepth), .histOverflow(histOverflow)
);

// File: tb/retStackRepair_bench.sv
module retStackRepair_bench;
  localparam int AW = 32;
  localparam int S = 4;
  localparam int H = 4;
  localparam int DW = $clog2(S + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic predValid = 1'b0;
  logic [AW-1:0] predAddr = '0;
  logic [1:0] predType = 2'b00;
  logic [AW-1:0] predTarget;
  logic flushValid = 1'b0;
  logic [AW-1:0] flushAddr = '0;
  logic updValid = 1'b0;
  logic [AW-1:0] updAddr = '0;
  logic [DW-1:0] stackDepth;
  logic histOverflow;

  int nChecks = 0;
  int nFails = 0;

  always #10 clk = ~clk;

  retStackRepair #(.ADDR_W(AW), .DEPTH(S), .HIST(H)) u_retStackRepair (
    .clk(clk), .rstN(rstN),
    .predValid(predValid), .predAddr(predAddr), .predType(predType),
    .predTarget(predTarget),
    .flushValid(flushValid), .flushAddr(flushAddr),
    .updValid(updValid), .updAddr(updAddr),
    .stackDepth(stackDepth), .histOverflow(histOverflow)
  );

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    predValid = 1'b0; flushValid = 1'b0; updValid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic pred(input logic [AW-1:0] a, input logic [1:0] t);
    @(negedge clk);
    predValid = 1'b1; predAddr = a; predType = t;
    @(negedge clk);
    predValid = 1'b0;
  endtask

  task automatic flush(input logic [AW-1:0] a);
    @(negedge clk);
    flushValid = 1'b1; flushAddr = a;
    @(negedge clk);
    flushValid = 1'b0;
  endtask

  task automatic upd(input logic [AW-1:0] a);
    @(negedge clk);
    updValid = 1'b1; updAddr = a;
    @(negedge clk);
    updValid = 1'b0;
  endtask

  task automatic tReset();
    doReset();
    chk("R1 depth", AW'(stackDepth), 0);
    chk("R1 target", predTarget, 0);
    chk("R1 overflow", AW'(histOverflow), 0);
  endtask

  task automatic tCallRet();
    doReset();
    pred(32'h100, 2'b01);
    chk("R2 target", predTarget, 32'h104);
    chk("R2 depth", AW'(stackDepth), 1);
    pred(32'h200, 2'b01);
    chk("R2 target2", predTarget, 32'h204);
    @(negedge clk);
    predValid = 1'b1; predAddr = 32'h300; predType = 2'b10;
    #1 chk("R3 same-cycle target", predTarget, 32'h204);
    @(negedge clk);
    predValid = 1'b0;
    chk("R3 depth", AW'(stackDepth), 1);
    chk("R3 next target", predTarget, 32'h104);
  endtask

  task automatic tFull();
    doReset();
    for (int i = 1; i <= 5; i++) pred(AW'(i * 16), 2'b01);
    chk("R4 depth saturates", AW'(stackDepth), S);
    for (int i = 5; i >= 2; i--) begin
      chk("R4 lifo target", predTarget, AW'(i * 16 + 4));
      pred(AW'(32'h900 + i), 2'b10);
    end
    chk("R4 oldest dropped", predTarget, 0);
    chk("R4 empty", AW'(stackDepth), 0);
  endtask

  task automatic tEmptyRet();
    doReset();
    @(negedge clk);
    predValid = 1'b1; predAddr = 32'h400; predType = 2'b10;
    #1 chk("R5 empty target", predTarget, 0);
    @(negedge clk);
    predValid = 1'b0;
    chk("R5 depth stays 0", AW'(stackDepth), 0);
    pred(32'h500, 2'b01);
    flush(32'h400);
    chk("R5 no record", AW'(stackDepth), 1);
    chk("R5 top kept", predTarget, 32'h504);
  endtask

  task automatic tFlushCall();
    doReset();
    pred(32'h100, 2'b01);
    pred(32'h200, 2'b01);
    flush(32'h200);
    chk("R6 depth", AW'(stackDepth), 1);
    chk("R6 target", predTarget, 32'h104);
  endtask

  task automatic tFlushRet();
    doReset();
    pred(32'h100, 2'b01);
    pred(32'h200, 2'b01);
    pred(32'h300, 2'b10);
    flush(32'h300);
    chk("R7 depth", AW'(stackDepth), 2);
    chk("R7 target restored", predTarget, 32'h204);
    flush(32'h200);
    flush(32'h100);
    chk("R6 full unwind", AW'(stackDepth), 0);
  endtask

  task automatic tUnknown();
    doReset();
    pred(32'h100, 2'b01);
    flush(32'h777);
    chk("R8 depth", AW'(stackDepth), 1);
    chk("R8 target", predTarget, 32'h104);
  endtask

  task automatic tUpdate();
    doReset();
    pred(32'h100, 2'b01);
    upd(32'h100);
    chk("R9 update keeps stack", AW'(stackDepth), 1);
    flush(32'h100);
    chk("R9 retired flush ignored", AW'(stackDepth), 1);
  endtask

  task automatic tOverflow();
    doReset();
    for (int i = 1; i <= 4; i++) pred(AW'(i * 256), 2'b01);
    chk("R10 no overflow yet", AW'(histOverflow), 0);
    pred(32'h500, 2'b01);
    chk("R10 overflow set", AW'(histOverflow), 1);
    chk("R10 push still done", predTarget, 32'h504);
    flush(32'h500);
    chk("R10 unrecorded flush", predTarget, 32'h504);
    chk("R10 sticky", AW'(histOverflow), 1);
  endtask

  task automatic tPriority();
    doReset();
    pred(32'h100, 2'b01);
    @(negedge clk);
    flushValid = 1'b1; flushAddr = 32'h100;
    predValid = 1'b1; predAddr = 32'h200; predType = 2'b01;
    @(negedge clk);
    flushValid = 1'b0; predValid = 1'b0;
    chk("R11 depth", AW'(stackDepth), 0);
    chk("R11 target", predTarget, 0);
  endtask

  task automatic tReplace();
    doReset();
    pred(32'h100, 2'b01);
    pred(32'h100, 2'b10);
    chk("R12 popped", AW'(stackDepth), 0);
    flush(32'h100);
    chk("R12 depth", AW'(stackDepth), 1);
    chk("R12 restored target", predTarget, 32'h104);
  endtask

  task automatic tPlain();
    doReset();
    pred(32'h100, 2'b01);
    pred(32'h200, 2'b00);
    pred(32'h300, 2'b11);
    chk("R13 depth", AW'(stackDepth), 1);
    chk("R13 target", predTarget, 32'h104);
    flush(32'h200);
    chk("R13 no record", AW'(stackDepth), 1);
  endtask

  initial begin
    fork
      begin
        tReset();
        tCallRet();
        tFull();
        tEmptyRet();
        tFlushCall();
        tFlushRet();
        tUnknown();
        tUpdate();
        tOverflow();
        tPriority();
        tReplace();
        tPlain();
      end
      begin
        repeat (5000) @(posedge clk);
        nChecks++;
        nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule